// File: doc/BRIEF.md
# Conditioned-Operand Arithmetic Logic Unit

This is a purely combinational arithmetic-logic unit for a small datapath. Two operands enter the unit. Each one passes through its own conditioning stage, which can force the operand to zero and can then invert every bit. The conditioned operands go to a function unit with four operations: add, bitwise AND, bitwise XOR, and a one-bit right shift. The right shift moves a carry bit into the top of the word and returns the bit that drops off the bottom, so a surrounding sequencer can build rotates from it. The carry-in comes from a selector that picks the external carry line, a forced 0 or a forced 1.

An output stage places the result on a shared bus. It has two enables, one for the true value and one for the inverted value. When neither enable is set, the stage releases the bus so that another source can drive it. Carry-out, zero and negative flags are produced on every cycle. A surrounding controller combines operand inversion, forced carry and output inversion to get subtraction, negation, increment and complement.

Top module: `alu_core`

## Requirements
- R1: With op_i = 2'b00 (add), the result is (a' + b' + c) mod 2^W and cout_o is bit W of that sum. Here a' and b' are the conditioned operands and c is the selected carry-in.
- R2: With op_i = 2'b01 (AND), the result is a' & b' and cout_o is 0.
- R3: With op_i = 2'b10 (XOR), the result is a' ^ b' and cout_o is 0.
- R4: With op_i = 2'b11 (right shift), the result is {c, a'[W-1:1]}, cout_o is a'[0], and operand b has no effect.
- R5: Each operand is conditioned independently. If its zero control is 1, the operand is replaced by 0. After that, if its invert control is 1, every bit is inverted. Zeroing always comes before inversion.
- R6: cin_sel_i selects the carry-in: 2'b00 and 2'b11 take cin_i, 2'b01 forces 0, and 2'b10 forces 1.
- R7: With only oe_true_i set, y_o carries the result and bus_drive_o is 1.
- R8: With oe_inv_i set, y_o carries the bitwise inverse of the result, and bus_drive_o is 1. This holds whether or not oe_true_i is also set.
- R9: With neither enable set, y_o is high impedance and bus_drive_o is 0.
- R10: zero_o is 1 exactly when every bit of the flag value is 0. The flag value is the value on the bus, or the true result when the bus is released.
- R11: neg_o equals the most-significant bit of the flag value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | Left operand |
| b_i | input | W | Right operand |
| a_zero_i | input | 1 | Force left operand to zero |
| a_inv_i | input | 1 | Invert left operand after zeroing |
| b_zero_i | input | 1 | Force right operand to zero |
| b_inv_i | input | 1 | Invert right operand after zeroing |
| op_i | input | 2 | Operation: 00 add, 01 AND, 10 XOR, 11 right shift |
| cin_sel_i | input | 2 | Carry-in source: 00/11 external, 01 zero, 10 one |
| cin_i | input | 1 | External carry-in |
| oe_true_i | input | 1 | Drive true result onto bus |
| oe_inv_i | input | 1 | Drive inverted result onto bus |
| y_o | output | W | Result bus, high impedance when released |
| bus_drive_o | output | 1 | High while the unit drives y_o |
| cout_o | output | 1 | Carry-out of add or shift |
| zero_o | output | 1 | Flag value is all zeros |
| neg_o | output | 1 | Most-significant bit of flag value |

## Verification
Output inversion and flag generation act in the same cycle. The flags must follow the inverted bus value and not the raw result. To test this, the bench drives an all-ones AND result through the inverting enable and expects the zero flag high. It also drives an all-zero sum through the same enable and expects the negative flag high. The shift's carry path and the carry-in selector also meet in one cycle: forced and external carries are applied to shifts and to an operand-inverted add. Each result is compared with a model derived from the requirements.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned OP_W    = 2;
  localparam int unsigned NUM_OPS = 1 << OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 2'b00,
    OP_AND = 2'b01,
    OP_XOR = 2'b10,
    OP_SHR = 2'b11
  } alu_op_e;

  typedef enum logic [1:0] {
    CIN_EXT  = 2'b00,
    CIN_ZERO = 2'b01,
    CIN_ONE  = 2'b10,
    CIN_ALT  = 2'b11
  } cin_sel_e;
endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] opnd_i,
  input  logic         zero_i,
  input  logic         inv_i,
  output logic [W-1:0] opnd_o
);
  logic [W-1:0] zeroed;

  // zero first, then invert (R5)
  assign zeroed = zero_i ? '0 : opnd_i;
  assign opnd_o = zeroed ^ {W{inv_i}};
endmodule

// File: rtl/alu_func_unit.sv
module alu_func_unit
  import alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  alu_op_e      op_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  localparam int unsigned SUM_W = W + 1;

  logic [NUM_OPS-1:0]        sel;
  logic [NUM_OPS-1:0][W-1:0] res_by_op;
  logic [NUM_OPS-1:0]        co_by_op;
  logic [SUM_W-1:0]          sum;
  logic [NUM_OPS:0][W-1:0]   res_acc;
  logic [NUM_OPS:0]          co_acc;

  assign sel = NUM_OPS'(1) << op_i;
  assign sum = {1'b0, opa_i} + {1'b0, opb_i} + {{W{1'b0}}, cin_i};

  always_comb begin
    res_by_op[OP_ADD] = sum[W-1:0];
    co_by_op[OP_ADD]  = sum[W];
    res_by_op[OP_AND] = opa_i & opb_i;
    co_by_op[OP_AND]  = 1'b0;
    res_by_op[OP_XOR] = opa_i ^ opb_i;
    co_by_op[OP_XOR]  = 1'b0;
    res_by_op[OP_SHR] = {cin_i, opa_i[W-1:1]};
    co_by_op[OP_SHR]  = opa_i[0];
  end

  // one-hot gated OR tree: only the selected unit reaches the output
  assign res_acc[0] = '0;
  assign co_acc[0]  = 1'b0;
  for (genvar g = 0; g < NUM_OPS; g++) begin : g_gate
    assign res_acc[g+1] = res_acc[g] | (res_by_op[g] & {W{sel[g]}});
    assign co_acc[g+1]  = co_acc[g]  | (co_by_op[g] & sel[g]);
  end

  assign res_o  = res_acc[NUM_OPS];
  assign cout_o = co_acc[NUM_OPS];

  always_comb begin
    if (op_i == OP_AND) begin
      p_and_mask_r2: assert ((res_o & ~opa_i) == '0)
        else $error("AND result has bit outside operand a");
    end
    if (op_i == OP_SHR) begin
      p_shr_msb_r4: assert (res_o[W-1] == cin_i)
        else $error("shift msb does not match carry-in");
    end
  end
endmodule

// File: rtl/alu_out_stage.sv
module alu_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] res_i,
  input  logic         oe_true_i,
  input  logic         oe_inv_i,
  output logic [W-1:0] y_o,
  output logic         drive_o,
  output logic         zero_o,
  output logic         neg_o
);
  logic [W-1:0] flag_val;

  // inverting enable wins when both are set
  assign flag_val = oe_inv_i ? ~res_i : res_i;
  assign drive_o  = oe_true_i | oe_inv_i;
  assign y_o      = drive_o ? flag_val : {W{1'bz}};
  assign zero_o   = ~|flag_val;
  assign neg_o    = flag_val[W-1];
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         a_zero_i,
  input  logic         a_inv_i,
  input  logic         b_zero_i,
  input  logic         b_inv_i,
  input  logic [1:0]   op_i,
  input  logic [1:0]   cin_sel_i,
  input  logic         cin_i,
  input  logic         oe_true_i,
  input  logic         oe_inv_i,
  output logic [W-1:0] y_o,
  output logic         bus_drive_o,
  output logic         cout_o,
  output logic         zero_o,
  output logic         neg_o
);
  localparam int unsigned NUM_OPND = 2;

  logic [NUM_OPND-1:0][W-1:0] raw, cond;
  logic [NUM_OPND-1:0]        zero_ctl, inv_ctl;
  logic                       cin_eff;
  logic [W-1:0]               res;
  alu_op_e                    op;

  assign raw      = {b_i, a_i};
  assign zero_ctl = {b_zero_i, a_zero_i};
  assign inv_ctl  = {b_inv_i, a_inv_i};
  assign op       = alu_op_e'(op_i);

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_cond
    alu_operand_cond #(.W(W)) u_cond (
      .opnd_i (raw[g]),
      .zero_i (zero_ctl[g]),
      .inv_i  (inv_ctl[g]),
      .opnd_o (cond[g])
    );
  end

  always_comb begin
    unique case (cin_sel_e'(cin_sel_i))
      CIN_ZERO: cin_eff = 1'b0;
      CIN_ONE:  cin_eff = 1'b1;
      CIN_EXT,
      CIN_ALT:  cin_eff = cin_i;
      default:  cin_eff = cin_i;
    endcase
  end

  alu_func_unit #(.W(W)) u_func (
    .opa_i  (cond[0]),
    .opb_i  (cond[1]),
    .op_i   (op),
    .cin_i  (cin_eff),
    .res_o  (res),
    .cout_o (cout_o)
  );

  alu_out_stage #(.W(W)) u_out (
    .res_i     (res),
    .oe_true_i (oe_true_i),
    .oe_inv_i  (oe_inv_i),
    .y_o       (y_o),
    .drive_o   (bus_drive_o),
    .zero_o    (zero_o),
    .neg_o     (neg_o)
  );

  always_comb begin
    if (op == OP_AND || op == OP_XOR) begin
      p_logic_nocarry_r3: assert (!cout_o) else $error("carry-out set on logic op");
    end
    if (op == OP_SHR) begin
      p_shr_cout_r4: assert (cout_o == cond[0][0]) else $error("shift carry-out wrong");
    end
    if (a_zero_i && !a_inv_i && op == OP_AND) begin
      p_zeroed_opnd_r5: assert (res == '0) else $error("zeroed operand leaked");
    end
    if (!oe_inv_i) begin
      p_zero_true_r10: assert (zero_o == (res == '0)) else $error("zero flag mismatch");
      p_neg_true_r11: assert (neg_o == res[W-1]) else $error("neg flag mismatch");
    end else begin
      p_neg_inv_r8: assert (neg_o == !res[W-1]) else $error("neg flag ignores inversion");
    end
  end
endmodule

// File: tb/alu_core_tb.sv
module alu_core_tb;
  localparam int unsigned W        = 8;
  localparam time         CLK_PER  = 10ns;
  localparam int unsigned WDOG_MAX = 10000;
  localparam int unsigned NVEC     = 17;

  typedef struct packed {
    logic [W-1:0] a, b;
    logic         za, na, zb, nb;
    logic [1:0]   op, csel;
    logic         cin, et, ei;
    logic [W-1:0] ey;
    logic         ecout, ezero, eneg, edrv;
  } vec_t;

  // a b za na zb nb op csel cin et ei | y cout zero neg drv
  localparam vec_t VECS [NVEC] = '{
    '{8'h12, 8'h34, 0,0,0,0, 2'b00, 2'b00, 0, 1,0, 8'h46, 0,0,0,1}, // R1
    '{8'hFF, 8'h01, 0,0,0,0, 2'b00, 2'b00, 0, 1,0, 8'h00, 1,1,0,1}, // R1 carry-out
    '{8'h10, 8'h20, 0,0,0,0, 2'b00, 2'b10, 0, 1,0, 8'h31, 0,0,0,1}, // R6 forced 1
    '{8'h10, 8'h20, 0,0,0,0, 2'b00, 2'b01, 1, 1,0, 8'h30, 0,0,0,1}, // R6 forced 0
    '{8'hF0, 8'h3C, 0,0,0,0, 2'b01, 2'b00, 1, 1,0, 8'h30, 0,0,0,1}, // R2
    '{8'hAA, 8'hFF, 0,0,0,0, 2'b10, 2'b00, 1, 1,0, 8'h55, 0,0,0,1}, // R3
    '{8'h81, 8'h5A, 0,0,0,0, 2'b11, 2'b00, 1, 1,0, 8'hC0, 1,0,1,1}, // R4
    '{8'h02, 8'hFF, 0,0,0,0, 2'b11, 2'b01, 1, 1,0, 8'h01, 0,0,0,1}, // R4 R6
    '{8'h55, 8'h5A, 1,1,0,0, 2'b01, 2'b00, 0, 1,0, 8'h5A, 0,0,0,1}, // R5 order
    '{8'h33, 8'h0F, 0,0,0,1, 2'b10, 2'b00, 0, 1,0, 8'hC3, 0,0,1,1}, // R5 R11
    '{8'h05, 8'h03, 0,0,0,1, 2'b00, 2'b10, 0, 1,0, 8'h02, 1,0,0,1}, // R1 R5 subtract
    '{8'hFF, 8'hFF, 0,0,0,0, 2'b01, 2'b00, 0, 0,1, 8'h00, 0,1,0,1}, // R8 R10
    '{8'h00, 8'h00, 0,0,0,0, 2'b00, 2'b00, 0, 0,1, 8'hFF, 0,0,1,1}, // R8 R11
    '{8'h00, 8'h00, 0,0,0,0, 2'b00, 2'b00, 0, 0,0, 8'h00, 0,1,0,0}, // R9 R10
    '{8'h0F, 8'h00, 0,0,0,0, 2'b10, 2'b00, 0, 1,1, 8'hF0, 0,0,1,1}, // R8 both
    '{8'h01, 8'h01, 0,0,0,0, 2'b00, 2'b11, 1, 1,0, 8'h03, 0,0,0,1}, // R6 alt code
    '{8'h42, 8'h77, 0,0,1,0, 2'b00, 2'b00, 0, 1,0, 8'h42, 0,0,0,1}  // R5 zero b
  };

  logic         clk, rst_ni;
  logic [W-1:0] a_i, b_i, y_o;
  logic         a_zero_i, a_inv_i, b_zero_i, b_inv_i, cin_i, oe_true_i, oe_inv_i;
  logic [1:0]   op_i, cin_sel_i;
  logic         bus_drive_o, cout_o, zero_o, neg_o;
  int           n_checks = 0, n_errors = 0;
  logic         done = 1'b0;

  alu_core #(.W(W)) u_dut (
    .a_i, .b_i, .a_zero_i, .a_inv_i, .b_zero_i, .b_inv_i, .op_i, .cin_sel_i,
    .cin_i, .oe_true_i, .oe_inv_i, .y_o, .bus_drive_o, .cout_o, .zero_o, .neg_o
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    a_i = v.a; b_i = v.b;
    a_zero_i = v.za; a_inv_i = v.na; b_zero_i = v.zb; b_inv_i = v.nb;
    op_i = v.op; cin_sel_i = v.csel; cin_i = v.cin;
    oe_true_i = v.et; oe_inv_i = v.ei;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG_MAX) begin
        n_checks++; n_errors++;
        $display("FAIL watchdog: got %0d expected < %0d cycles", cyc, WDOG_MAX);
        finish_run();
      end
    end
  end

  initial begin
    vec_t v;
    rst_ni = 1'b0;
    a_i = '0; b_i = '0; a_zero_i = 0; a_inv_i = 0; b_zero_i = 0; b_inv_i = 0;
    op_i = '0; cin_sel_i = '0; cin_i = 0; oe_true_i = 0; oe_inv_i = 0;
    repeat (2) @(posedge clk);
    #1;
    // idle state: bus released (R9), flags on 0+0 (R10)
    check("R9 idle drive", W'(bus_drive_o), W'(1'b0));
    check("R10 idle zero", W'(zero_o), W'(1'b1));
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      v = VECS[i];
      apply(v);
      if (v.edrv) check($sformatf("vec%0d y R1 R2 R3 R4 R7 R8", i), y_o, v.ey);
      check($sformatf("vec%0d cout R1 R4", i), W'(cout_o), W'(v.ecout));
      check($sformatf("vec%0d zero R10", i), W'(zero_o), W'(v.ezero));
      check($sformatf("vec%0d neg R11", i), W'(neg_o), W'(v.eneg));
      check($sformatf("vec%0d drive R9", i), W'(bus_drive_o), W'(v.edrv));
    end

    // R4 rotate: two shifts feeding carry-out back as external carry
    v = '{8'h01, 8'h00, 0,0,0,0, 2'b11, 2'b00, 0, 1,0, 8'h00, 1,1,0,1};
    apply(v);
    check("R4 rot1 y", y_o, 8'h00);
    check("R4 rot1 cout", W'(cout_o), W'(1'b1));
    v.a = y_o; v.cin = cout_o;
    apply(v);
    check("R4 rot2 y", y_o, 8'h80);
    check("R4 rot2 cout", W'(cout_o), W'(1'b0));

    // R4: operand b has no effect on shift
    v = '{8'h6C, 8'hFF, 0,0,1,1, 2'b11, 2'b10, 0, 1,0, 8'hB6, 0,0,1,1};
    apply(v);
    check("R4 b ignored y", y_o, 8'hB6);
    check("R4 b ignored cout", W'(cout_o), W'(1'b0));

    // R7 true-only after inverted: value returns to true result
    v = '{8'hC3, 8'h0F, 0,0,0,0, 2'b01, 2'b00, 0, 1,0, 8'h03, 0,0,0,1};
    apply(v);
    check("R7 true path", y_o, 8'h03);

    // R9 released bus, flags still track true result (R11)
    v.et = 0; v.a = 8'hF0; v.b = 8'hF0;
    apply(v);
    check("R9 released drive", W'(bus_drive_o), W'(1'b0));
    check("R11 released neg", W'(neg_o), W'(1'b1));
    check("R10 released zero", W'(zero_o), W'(1'b0));

    done = 1'b1;
    finish_run();
  end
endmodule